// File: doc/BRIEF.md
# Passive Wormhole Configuration Stream Router

This block steers configuration streams (worms) between neighbouring configurable tiles. Each input port carries a sequence of flits. The first flit (head) names its outgoing direction in a small code field. The last flit (tail) ends the worm. When a head arrives and its output is free, the router grants the output to that input. The output stays locked to that input until the tail has been handed over, and then it is free again. The route comes only from the code in the head. The router holds no congestion state and does no adaptive steering. Conflicts are assumed to have been resolved when the streams were compiled.

The router has no buffering. A flit moves from input to output in the same cycle, under valid/ready handshakes on every port. A stalled output therefore holds back the owning input directly. Before forwarding a head, the router shifts out the code it consumed, so the next hop finds its own code in the same bit positions. Set the port count to 4 for a router beside an interior tile, or to 3 for a router on the array edge. The same per-output unit is replicated once per port.

Top module: `wormhole_router`

## Requirements
- R1: After reset no output is locked, and with all inputs idle every outValid and every inReady is 0.
- R2: A flit is DATA_W+2 bits: bit DATA_W+1 is the head marker, bit DATA_W is the tail marker, and bits DATA_W-1:0 are payload. In a head flit, payload bits 1:0 give the output index (0 to NUM_PORTS-1), and the head is presented on that output.
- R3: A forwarded head keeps both marker bits. Its payload is the input payload shifted right by 2, with zeros shifted in at the top. Non-head flits are forwarded unchanged.
- R4: Once an input is granted an output, every later flit of that input goes to the same output until a flit with the tail marker is accepted there. After that, the output is free from the next cycle.
- R5: While an output is locked, a head from any other input that names that output sees inReady low and is not forwarded.
- R6: Worms that name different free outputs all advance in the same cycle.
- R7: When several heads name the same free output, the winner is the first requester found by scanning upward, with wrap-around, from a per-output pointer. The pointer starts at 0 after reset and moves to the winner's index plus one.
- R8: When outReady is low, the owning input sees inReady low, and outValid and outData hold their values. Every flit accepted at an input is delivered exactly once.
- R9: A flit that carries both markers crosses alone and leaves its output free in the following cycle.
- R10: With NUM_PORTS set to 3, the same behaviour holds using output indices 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | NUM_PORTS | Flit offered on each input |
| inData | input | NUM_PORTS*(DATA_W+2) | Flit per input; input i occupies slice i |
| inReady | output | NUM_PORTS | Flit taken from each input this cycle |
| outValid | output | NUM_PORTS | Flit offered on each output |
| outData | output | NUM_PORTS*(DATA_W+2) | Flit per output; output o occupies slice o |
| outReady | input | NUM_PORTS | Downstream accepts the offered flit |

## Verification
The hardest case to reach from the ports combines three conditions. A worm holds a locked output while its downstream stalls. Its own sender leaves gaps mid-worm. Rival heads keep waiting for that same output. Only then do the pointer movement and the hand-over at the tail matter. The stimulus queues several multi-flit worms that all name one output. It drives outReady low at random and inserts random gaps between flits. A behavioural model predicts outValid, outData and inReady each cycle for both a four-port and a three-port instance.

// File: rtl/wr_pkg.sv
package wr_pkg;
  localparam int MAX_PORTS = 4;
  localparam int DIR_W = 2;

  // sel[o][i]: input i currently drives output o
  typedef struct packed {
    logic [MAX_PORTS-1:0][MAX_PORTS-1:0] sel;
  } wr_strobe_t;
endpackage

// File: rtl/wr_out_arb.sv
module wr_out_arb #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] req,
  input  logic [NUM_PORTS-1:0] inValid,
  input  logic [NUM_PORTS-1:0] inTail,
  input  logic                 outReady,
  output logic [NUM_PORTS-1:0] sel
);
  localparam int IDX_W = $clog2(NUM_PORTS);

  logic             locked;
  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] ptr;
  logic [NUM_PORTS-1:0] grantVec;
  logic [NUM_PORTS-1:0] ownerVec;
  logic [IDX_W-1:0] grantIdx;
  logic             found;
  logic             accept;
  logic             endOfWorm;

  always_comb begin
    logic [IDX_W:0] c;
    grantVec = '0;
    grantIdx = '0;
    found    = 1'b0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      c = {1'b0, ptr} + (IDX_W+1)'(k);
      if (c >= (IDX_W+1)'(NUM_PORTS)) c = c - (IDX_W+1)'(NUM_PORTS);
      if (!found && req[c[IDX_W-1:0]]) begin
        found = 1'b1;
        grantVec[c[IDX_W-1:0]] = 1'b1;
        grantIdx = c[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    ownerVec = '0;
    ownerVec[owner] = 1'b1;
  end

  assign sel       = locked ? ownerVec : grantVec;
  assign accept    = (|(sel & inValid)) & outReady;
  assign endOfWorm = accept & (|(sel & inTail));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (locked) begin
      if (endOfWorm) locked <= 1'b0;
    end else if (found) begin
      ptr <= (grantIdx == IDX_W'(NUM_PORTS-1)) ? '0 : grantIdx + 1'b1;
      if (!endOfWorm) begin
        locked <= 1'b1;
        owner  <= grantIdx;
      end
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !endOfWorm) |=> (locked && $stable(owner)));

  // R9
  single_flit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && endOfWorm) |=> !locked);
endmodule

// File: rtl/wr_ctrl.sv
module wr_ctrl
  import wr_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PORTS-1:0]             inValid,
  input  logic [NUM_PORTS-1:0]             inHead,
  input  logic [NUM_PORTS-1:0]             inTail,
  input  logic [NUM_PORTS-1:0][DIR_W-1:0]  inDir,
  input  logic [NUM_PORTS-1:0]             outReady,
  output wr_strobe_t                       strobe,
  output logic [NUM_PORTS-1:0]             inReady
);
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] selM;

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    logic [NUM_PORTS-1:0] req;
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_req
      assign req[i] = inValid[i] & inHead[i] & (inDir[i] == DIR_W'(o));
    end
    wr_out_arb #(.NUM_PORTS(NUM_PORTS)) arb_i (
      .clk(clk), .rstN(rstN), .req(req), .inValid(inValid),
      .inTail(inTail), .outReady(outReady[o]), .sel(selM[o])
    );
  end

  always_comb begin
    strobe  = '0;
    inReady = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        strobe.sel[o][i] = selM[o][i];
        if (selM[o][i] && outReady[o]) inReady[i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_col
    logic [NUM_PORTS-1:0] colSel;
    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_bit
      assign colSel[o] = selM[o][i];
    end
    // R6
    one_path_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(colSel));
  end
endmodule

// File: rtl/wr_datapath.sv
module wr_datapath
  import wr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wr_strobe_t                    strobe,
  input  logic [NUM_PORTS-1:0]          inValid,
  input  logic [NUM_PORTS*(DATA_W+2)-1:0] inData,
  output logic [NUM_PORTS-1:0]          outValid,
  output logic [NUM_PORTS*(DATA_W+2)-1:0] outData
);
  localparam int FW = DATA_W + 2;

  always_comb begin
    logic [FW-1:0] pick;
    outValid = '0;
    outData  = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      pick = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (strobe.sel[o][i]) begin
          outValid[o] = inValid[i];
          pick = inData[i*FW +: FW];
        end
      end
      if (pick[FW-1]) pick = {pick[FW-1:FW-2], {DIR_W{1'b0}}, pick[DATA_W-1:DIR_W]};
      outData[o*FW +: FW] = pick;
    end
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_chk
    // R3
    strip_chk: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[o] && outData[o*FW+FW-1]) |-> (outData[o*FW+DATA_W-1 -: DIR_W] == '0));
  end
endmodule

// File: rtl/wormhole_router.sv
module wormhole_router
  import wr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PORTS-1:0]            inValid,
  input  logic [NUM_PORTS*(DATA_W+2)-1:0] inData,
  output logic [NUM_PORTS-1:0]            inReady,
  output logic [NUM_PORTS-1:0]            outValid,
  output logic [NUM_PORTS*(DATA_W+2)-1:0] outData,
  input  logic [NUM_PORTS-1:0]            outReady
);
  localparam int FW = DATA_W + 2;

  logic [NUM_PORTS-1:0]            inHead;
  logic [NUM_PORTS-1:0]            inTail;
  logic [NUM_PORTS-1:0][DIR_W-1:0] inDir;
  wr_strobe_t                      strobe;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_unpack
    assign inHead[i] = inData[i*FW + FW-1];
    assign inTail[i] = inData[i*FW + FW-2];
    assign inDir[i]  = inData[i*FW +: DIR_W];
  end

  wr_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHead(inHead),
    .inTail(inTail), .inDir(inDir), .outReady(outReady),
    .strobe(strobe), .inReady(inReady)
  );

  wr_datapath #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  // R8
  conserve_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(inValid & inReady) == $countones(outValid & outReady));

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_hold
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[o] && !outReady[o]) |=> (outValid[o] && $stable(outData[o*FW +: FW])));
  end
endmodule

// File: tb/wormhole_router_tb_top.sv
module wormhole_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int FW = DW + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]          inV [2];
  logic [3:0][FW-1:0]  inD [2];
  logic [3:0]          oR  [2];
  logic [3:0]          oVa [2];
  logic [3:0][FW-1:0]  oDa [2];
  logic [3:0]          iRa [2];

  logic [3:0]        oV4, iR4;
  logic [4*FW-1:0]   oD4;
  logic [2:0]        oV3, iR3;
  logic [3*FW-1:0]   oD3;

  wormhole_router #(.NUM_PORTS(4), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inV[0]), .inData(inD[0]),
    .inReady(iR4), .outValid(oV4), .outData(oD4), .outReady(oR[0])
  );

  wormhole_router #(.NUM_PORTS(3), .DATA_W(DW)) dut3_i (
    .clk(clk), .rstN(rstN), .inValid(inV[1][2:0]), .inData(inD[1][2:0]),
    .inReady(iR3), .outValid(oV3), .outData(oD3), .outReady(oR[1][2:0])
  );

  assign oVa[0] = oV4;
  assign iRa[0] = iR4;
  assign oDa[0] = oD4;
  assign oVa[1] = {1'b0, oV3};
  assign iRa[1] = {1'b0, iR3};
  assign oDa[1] = {{FW{1'b0}}, oD3};

  int nChecks = 0;
  int nErrors = 0;
  string curTag = "R1";
  int rdyMode = 0;
  int gapMode = 0;
  bit done = 0;

  logic [FW-1:0] fq [2][4][$];
  bit accM [2][4];
  int lockedM [2][4];
  int ownerM  [2][4];
  int ptrM    [2][4];

  function automatic int nP(int l);
    return (l == 0) ? 4 : 3;
  endfunction

  function automatic logic [FW-1:0] strip(logic [FW-1:0] f);
    if (f[FW-1]) return {f[FW-1:FW-2], 2'b00, f[DW-1:2]};
    return f;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // reference model, stepped once per cycle
  always @(negedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < 2; l++) begin
        inV[l] = '0; inD[l] = '0; oR[l] = '0;
        for (int p = 0; p < 4; p++) begin
          lockedM[l][p] = 0; ownerM[l][p] = 0; ptrM[l][p] = 0; accM[l][p] = 0;
        end
      end
    end else begin
      for (int l = 0; l < 2; l++) begin
        for (int i = 0; i < nP(l); i++) begin
          if (accM[l][i]) begin
            void'(fq[l][i].pop_front());
            inV[l][i] = 1'b0;
          end
          if (!inV[l][i] && fq[l][i].size() > 0 && (gapMode == 0 || $urandom % 3 != 0)) begin
            inV[l][i] = 1'b1;
            inD[l][i] = fq[l][i][0];
          end
        end
        for (int o = 0; o < nP(l); o++) oR[l][o] = (rdyMode == 0) ? 1'b1 : ($urandom % 4 != 0);
      end
      #1;
      for (int l = 0; l < 2; l++) begin
        int expSel [4];
        int n;
        n = nP(l);
        for (int o = 0; o < n; o++) begin
          expSel[o] = -1;
          if (lockedM[l][o] != 0) expSel[o] = ownerM[l][o];
          else begin
            for (int k = 0; k < n; k++) begin
              int c;
              c = (ptrM[l][o] + k) % n;
              if (expSel[o] < 0 && inV[l][c] && inD[l][c][FW-1] && int'(inD[l][c][1:0]) == o)
                expSel[o] = c;
            end
          end
        end
        for (int o = 0; o < n; o++) begin
          bit ev;
          ev = (expSel[o] >= 0) && inV[l][expSel[o]];
          chk(oVa[l][o] == ev, curTag, $sformatf("lane%0d outValid[%0d]", l, o), oVa[l][o], ev);
          if (ev) chk(oDa[l][o] == strip(inD[l][expSel[o]]), curTag,
                      $sformatf("lane%0d outData[%0d]", l, o), oDa[l][o], strip(inD[l][expSel[o]]));
        end
        for (int i = 0; i < n; i++) begin
          bit er;
          er = 0;
          for (int o = 0; o < n; o++) if (expSel[o] == i && oR[l][o]) er = 1;
          chk(iRa[l][i] == er, curTag, $sformatf("lane%0d inReady[%0d]", l, i), iRa[l][i], er);
          accM[l][i] = inV[l][i] && iRa[l][i];
        end
        for (int o = 0; o < n; o++) begin
          bit endW;
          endW = (expSel[o] >= 0) && inV[l][expSel[o]] && oR[l][o] && inD[l][expSel[o]][FW-2];
          if (lockedM[l][o] != 0) begin
            if (endW) lockedM[l][o] = 0;
          end else if (expSel[o] >= 0) begin
            ptrM[l][o] = (expSel[o] + 1) % n;
            if (!endW) begin lockedM[l][o] = 1; ownerM[l][o] = expSel[o]; end
          end
        end
      end
    end
  end

  task automatic pushWorm(int l, int src, int dir, int len);
    logic [FW-1:0] f;
    for (int k = 0; k < len; k++) begin
      f[DW-1:0] = DW'($urandom);
      f[FW-1] = (k == 0);
      f[FW-2] = (k == len - 1);
      if (k == 0) f[1:0] = 2'(dir);
      fq[l][src].push_back(f);
    end
  endtask

  task automatic drain(string tag);
    int cyc;
    bit empty;
    cyc = 0;
    empty = 0;
    while (!empty && cyc < 4000) begin
      @(negedge clk); #3;
      cyc++;
      empty = 1;
      for (int l = 0; l < 2; l++)
        for (int i = 0; i < 4; i++)
          if (fq[l][i].size() != 0 || inV[l][i]) empty = 0;
    end
    chk(empty, tag, "all worms delivered", empty, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    // R1 reset state with idle inputs
    chk(oVa[0] == 4'b0, "R1", "outValid after reset", oVa[0], 0);
    chk(iRa[0] == 4'b0, "R1", "inReady after reset", iRa[0], 0);
    rstN = 1'b1;
    @(negedge clk); #3;
    chk(oVa[0] == 4'b0 && oVa[1] == 4'b0, "R1", "outValid idle", oVa[0], 0);

    // R2 / R3: one worm to each direction
    curTag = "R2";
    for (int d = 0; d < 4; d++) pushWorm(0, 1, d, 3);
    drain("R2");
    curTag = "R3";
    fq[0][0].push_back({2'b10, 8'b1011_0110});
    fq[0][0].push_back({2'b01, 8'hA5});
    @(negedge clk); #3;
    chk(oVa[0][2] && oDa[0][2] == {2'b10, 8'b0010_1101}, "R3", "stripped head", oDa[0][2], {2'b10, 8'b0010_1101});
    @(negedge clk); #3;
    chk(oVa[0][2] && oDa[0][2] == {2'b01, 8'hA5}, "R3", "tail unchanged", oDa[0][2], {2'b01, 8'hA5});
    drain("R3");

    // R4 / R5: two inputs contend for output 3
    curTag = "R5";
    pushWorm(0, 0, 3, 5);
    pushWorm(0, 2, 3, 4);
    @(negedge clk); #3;
    chk($countones(iRa[0]) == 1, "R5", "one contender moves", $countones(iRa[0]), 1);
    curTag = "R4";
    drain("R4");

    // R6: distinct outputs in parallel
    curTag = "R6";
    pushWorm(0, 0, 1, 3); pushWorm(0, 1, 2, 3);
    pushWorm(0, 2, 3, 3); pushWorm(0, 3, 0, 3);
    @(negedge clk); #3;
    chk(oVa[0] == 4'b1111, "R6", "all outputs busy", oVa[0], 4'hf);
    chk(iRa[0] == 4'b1111, "R6", "all inputs advance", iRa[0], 4'hf);
    drain("R6");

    // R7: four heads on one output, several rounds
    curTag = "R7";
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 4; s++) pushWorm(0, s, 1, 2 + s);
    @(negedge clk); #3;
    chk($countones(iRa[0]) == 1, "R7", "single winner", $countones(iRa[0]), 1);
    drain("R7");

    // R9: single-flit worms back to back on one output
    curTag = "R9";
    for (int s = 0; s < 4; s++) pushWorm(0, s, 0, 1);
    for (int s = 0; s < 4; s++) pushWorm(0, s, 0, 1);
    drain("R9");

    // R8: random stalls and sender gaps, mixed traffic on both lanes
    curTag = "R8";
    rdyMode = 1; gapMode = 1;
    for (int k = 0; k < 60; k++) pushWorm(0, $urandom % 4, $urandom % 4, 1 + $urandom % 5);
    for (int k = 0; k < 12; k++) pushWorm(0, k % 4, 2, 3);
    drain("R8");

    // R10: three-port instance
    curTag = "R10";
    for (int k = 0; k < 60; k++) pushWorm(1, $urandom % 3, $urandom % 3, 1 + $urandom % 5);
    drain("R10");
    rdyMode = 0; gapMode = 0;
    for (int s = 0; s < 3; s++) pushWorm(1, s, (s + 1) % 3, 2);
    @(negedge clk); #3;
    chk(oVa[1][2:0] == 3'b111, "R10", "three-port parallel", oVa[1], 7);
    drain("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog %s timeout", curTag);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule